// File: doc/BRIEF.md
# Four-Lane Column Deskew Controller

This block sits behind four byte-wide receive lanes whose code groups have already been decoded into a data byte and a control flag, and whose lane-level synchronisation has been judged elsewhere. Each lane can arrive with its own delay. The block finds the alignment control character on every lane and picks a per-lane delay tap from a short history buffer so that those characters leave the block in the same column. The four lanes then come out as one deskewed column per clock.

A column state machine grades the alignment. One complete column is consumed by the pointer search itself. Three further complete columns are needed before the status bit rises, and one partial column during that confirmation restarts the search. Once aligned, isolated partial columns only walk the machine through three failure levels. Each complete column walks it one level back. A fourth step drops alignment. While the status bit is low, the output bus carries a fixed local-fault column instead of lane data. Losing synchronisation on any lane drops the block straight back to the search.

Top module: `col_deskew_ctrl`

## Requirements
- R1: During and straight after synchronous active-low reset, `col_aligned_o` is 0 and the output carries the local-fault column. In that column `rx_ctrl_o` is 4'b0001. Lane 0 carries 0x9C, lanes 1 and 2 carry 0x00 and lane 3 carries 0x01, with lane l at `rx_data_o[8l+7:8l]`.
- R2: The alignment character is data byte 0x7C with the lane's control flag set. While searching, the block locks one delay tap per lane so that the first alignment character seen on each lane comes out in one column. This works for any inter-lane skew from 0 to 7 clocks.
- R3: If the skew between the earliest and the latest alignment character exceeds 7 clocks, the search discards the oldest finding and restarts, so alignment is never declared.
- R4: After the locking column, three further complete columns (the alignment character on all four lanes) are needed. The first output column with `col_aligned_o`=1 is the column that follows the third of these.
- R5: During the confirmation phase, a partial column (the alignment character on some lanes but not all) returns the block to the search with the status bit still 0.
- R6: While `col_aligned_o` is 0 the output is the local-fault column. While it is 1 the output is the deskewed lane data.
- R7: Once aligned, each partial column moves one failure level down. The first three keep `col_aligned_o` at 1, and the fourth clears it from the following output column on.
- R8: Within the failure levels, a complete column moves one level back toward full alignment. A column without the alignment character leaves the level unchanged.
- R9: A low `lane_sync_i` bit on any lane forces the search state at the next clock edge. The output column after that edge has `col_aligned_o`=0.
- R10: The outputs are registered. Each output column and its status bit reflect the deskewed column and the state of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_sync_i | input | 4 | Per-lane synchronisation good, 1 = in sync |
| lane_data_i | input | 32 | Decoded lane bytes, lane l in bits [8l+7:8l] |
| lane_ctrl_i | input | 4 | Per-lane control flag |
| rx_data_o | output | 32 | Deskewed bytes or local-fault column |
| rx_ctrl_o | output | 4 | Deskewed control flags or local-fault flags |
| col_aligned_o | output | 1 | Column alignment status |

## Verification
The bench builds the block with its defaults: four lanes and an eight-deep history per lane. This keeps the whole skew space small enough to sweep. Lane 0 stays at zero delay while lanes 1 and 3 each take every delay from 0 to 7, and lane 2 takes a delay derived from the other two. This reaches the exact 7-clock boundary on several lanes, and a separate run with an 8-clock skew checks that the search never locks. With zero skew, the output column index is a fixed function of the cycle count. That lets the bench place partial, complete and plain columns at chosen indices and check the status bit column by column through every failure level.

// File: rtl/cdsk_pkg.sv
// Shared types and constants for the column deskew controller.
package cdsk_pkg;

    // Column alignment states; encoding order carries no meaning.
    typedef enum logic [2:0] {
        ST_UNALIGN = 3'd0,
        ST_DET1    = 3'd1,
        ST_DET2    = 3'd2,
        ST_DET3    = 3'd3,
        ST_ALIGN   = 3'd4,
        ST_FAIL1   = 3'd5,
        ST_FAIL2   = 3'd6,
        ST_FAIL3   = 3'd7
    } col_state_e;

    localparam logic [7:0] ALIGN_CHAR = 8'h7C;  // alignment control code
    localparam logic [7:0] FAULT_SEQ  = 8'h9C;  // sequence control code, lane 0
    localparam logic [7:0] FAULT_LAST = 8'h01;  // local-fault value, last lane

    // True in the states where the column counts as aligned.
    function automatic logic is_aligned_state(input col_state_e s);
        return (s == ST_ALIGN) || (s == ST_FAIL1) ||
               (s == ST_FAIL2) || (s == ST_FAIL3);
    endfunction

endpackage

// File: rtl/cdsk_lane_buf.sv
// One lane's skew history and alignment-character search.
// Every byte is pushed into a DEPTH-entry shift history. While searching,
// the first alignment character seen is timed by an age counter. On lock
// the tap is set so the history entry holding that character is read.
// Assumes DEPTH is a power of two, so the tap indexes every entry.
module cdsk_lane_buf #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] byte_i,
    input  logic       ctrl_i,
    input  logic       search_en,
    input  logic       restart,
    input  logic       lock,
    output logic       hit_o,
    output logic       found_o,
    output logic       at_limit_o,
    output logic [7:0] col_byte_o,
    output logic       col_ctrl_o
);
    import cdsk_pkg::*;

    localparam int TAP_W = $clog2(DEPTH);

    logic [7:0]       hist_byte [DEPTH];
    logic [DEPTH-1:0] hist_ctrl;
    logic [TAP_W-1:0] age_q;
    logic [TAP_W-1:0] tap_q;
    logic             found_q;

    assign hit_o      = ctrl_i && (byte_i == ALIGN_CHAR);
    assign found_o    = found_q;
    assign at_limit_o = found_q && (age_q == TAP_W'(DEPTH - 1));
    assign col_byte_o = hist_byte[tap_q];
    assign col_ctrl_o = hist_ctrl[tap_q];

    // Shift every incoming byte and flag into the history.
    always_ff @(posedge clk) begin : shift_p
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_byte[i] <= '0;
            end
            hist_ctrl <= '0;
        end else begin
            hist_byte[0] <= byte_i;
            for (int i = 1; i < DEPTH; i++) begin
                hist_byte[i] <= hist_byte[i-1];
            end
            hist_ctrl <= {hist_ctrl[DEPTH-2:0], ctrl_i};
        end
    end

    // Time the first alignment character and set the read tap on lock.
    always_ff @(posedge clk) begin : search_p
        if (!rst_n) begin
            found_q <= 1'b0;
            age_q   <= '0;
            tap_q   <= '0;
        end else if (!search_en) begin
            found_q <= 1'b0;
            age_q   <= '0;
        end else if (restart) begin
            found_q <= hit_o;
            age_q   <= '0;
        end else if (lock) begin
            tap_q   <= found_q ? (age_q + TAP_W'(1)) : '0;
            found_q <= 1'b0;
            age_q   <= '0;
        end else if (found_q) begin
            age_q   <= age_q + TAP_W'(1);
        end else if (hit_o) begin
            found_q <= 1'b1;
            age_q   <= '0;
        end
    end

endmodule

// File: rtl/cdsk_col_fsm.sv
// Column alignment state machine with entry and exit hysteresis.
// Takes the per-lane alignment-character flags of the deskewed column.
// The column that follows a lock is the locking column itself and is
// skipped. Assumes lock is raised only in the search state.
module cdsk_col_fsm #(
    parameter int NUM_LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_all,
    input  logic                   lock,
    input  logic [NUM_LANES-1:0]   col_hit,
    output cdsk_pkg::col_state_e   state_o,
    output logic                   skip_o
);
    import cdsk_pkg::*;

    col_state_e state_q, state_d;
    logic       skip_q;
    logic       complete, partial;

    assign complete = &col_hit;
    assign partial  = (|col_hit) && !complete;
    assign state_o  = state_q;
    assign skip_o   = skip_q;

    // Next-state selection from the current column class.
    always_comb begin : next_p
        state_d = state_q;
        unique case (state_q)
            ST_UNALIGN: if (lock) state_d = ST_DET1;
            ST_DET1: if (!skip_q) begin
                if (complete)     state_d = ST_DET2;
                else if (partial) state_d = ST_UNALIGN;
            end
            ST_DET2: begin
                if (complete)     state_d = ST_DET3;
                else if (partial) state_d = ST_UNALIGN;
            end
            ST_DET3: begin
                if (complete)     state_d = ST_ALIGN;
                else if (partial) state_d = ST_UNALIGN;
            end
            ST_ALIGN: if (partial) state_d = ST_FAIL1;
            ST_FAIL1: begin
                if (partial)       state_d = ST_FAIL2;
                else if (complete) state_d = ST_ALIGN;
            end
            ST_FAIL2: begin
                if (partial)       state_d = ST_FAIL3;
                else if (complete) state_d = ST_FAIL1;
            end
            ST_FAIL3: begin
                if (partial)       state_d = ST_UNALIGN;
                else if (complete) state_d = ST_FAIL2;
            end
            default: state_d = ST_UNALIGN;
        endcase
    end

    // State register; lane sync loss overrides everything.
    always_ff @(posedge clk) begin : state_p
        if (!rst_n || !sync_all) begin
            state_q <= ST_UNALIGN;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            skip_q  <= lock;
        end
    end

endmodule

// File: rtl/cdsk_out_stage.sv
// Output register: the deskewed column, or the local-fault column when
// not aligned. Lane 0 carries the sequence control code, the last lane
// carries the fault value, and the lanes between carry zero data.
module cdsk_out_stage #(
    parameter int NUM_LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     aligned_i,
    input  logic [8*NUM_LANES-1:0]   col_data_i,
    input  logic [NUM_LANES-1:0]     col_ctrl_i,
    output logic [8*NUM_LANES-1:0]   data_o,
    output logic [NUM_LANES-1:0]     ctrl_o,
    output logic                     aligned_o
);
    import cdsk_pkg::*;

    logic [8*NUM_LANES-1:0] fault_data;
    logic [NUM_LANES-1:0]   fault_ctrl;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_fault
        assign fault_data[8*l +: 8] = (l == 0) ? FAULT_SEQ :
                                      (l == NUM_LANES - 1) ? FAULT_LAST : 8'h00;
        assign fault_ctrl[l]        = (l == 0);
    end

    // Register the column and status, substituting the fault column.
    always_ff @(posedge clk) begin : out_p
        if (!rst_n) begin
            data_o    <= fault_data;
            ctrl_o    <= fault_ctrl;
            aligned_o <= 1'b0;
        end else begin
            data_o    <= aligned_i ? col_data_i : fault_data;
            ctrl_o    <= aligned_i ? col_ctrl_i : fault_ctrl;
            aligned_o <= aligned_i;
        end
    end

endmodule

// File: rtl/col_deskew_ctrl.sv
// Four-lane column deskew controller, top level.
// One history buffer per lane, a shared search and lock decision, the
// column state machine and the registered output stage.
// Assumes the lane inputs are already decoded and synchronised.
module col_deskew_ctrl #(
    parameter int NUM_LANES = 4,
    parameter int DEPTH     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LANES-1:0]     lane_sync_i,
    input  logic [8*NUM_LANES-1:0]   lane_data_i,
    input  logic [NUM_LANES-1:0]     lane_ctrl_i,
    output logic [8*NUM_LANES-1:0]   rx_data_o,
    output logic [NUM_LANES-1:0]     rx_ctrl_o,
    output logic                     col_aligned_o
);
    import cdsk_pkg::*;

    col_state_e             state_q;
    logic                   skip;
    logic                   sync_all, search_en, restart, lock;
    logic [NUM_LANES-1:0]   hit, found, at_limit, col_hit, col_ctrl;
    logic [8*NUM_LANES-1:0] col_data;

    assign sync_all  = &lane_sync_i;
    assign search_en = (state_q == ST_UNALIGN) && sync_all;
    assign restart   = search_en && (|at_limit);
    assign lock      = search_en && !restart && (&(found | hit));

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        cdsk_lane_buf #(.DEPTH(DEPTH)) buf_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .byte_i     (lane_data_i[8*l +: 8]),
            .ctrl_i     (lane_ctrl_i[l]),
            .search_en  (search_en),
            .restart    (restart),
            .lock       (lock),
            .hit_o      (hit[l]),
            .found_o    (found[l]),
            .at_limit_o (at_limit[l]),
            .col_byte_o (col_data[8*l +: 8]),
            .col_ctrl_o (col_ctrl[l])
        );
        assign col_hit[l] = col_ctrl[l] && (col_data[8*l +: 8] == ALIGN_CHAR);
    end

    cdsk_col_fsm #(.NUM_LANES(NUM_LANES)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_all (sync_all),
        .lock     (lock),
        .col_hit  (col_hit),
        .state_o  (state_q),
        .skip_o   (skip)
    );

    cdsk_out_stage #(.NUM_LANES(NUM_LANES)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .aligned_i  (is_aligned_state(state_q)),
        .col_data_i (col_data),
        .col_ctrl_i (col_ctrl),
        .data_o     (rx_data_o),
        .ctrl_o     (rx_ctrl_o),
        .aligned_o  (col_aligned_o)
    );

endmodule

// File: rtl/col_deskew_ctrl_chk.sv
// Property checker for the column deskew controller, bound to the top.
module col_deskew_ctrl_chk #(
    parameter int NUM_LANES = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_LANES-1:0]     lane_sync_i,
    input cdsk_pkg::col_state_e     state_q,
    input logic                     lock,
    input logic                     skip,
    input logic [NUM_LANES-1:0]     col_hit,
    input logic [8*NUM_LANES-1:0]   rx_data_o,
    input logic [NUM_LANES-1:0]     rx_ctrl_o,
    input logic                     col_aligned_o
);
    import cdsk_pkg::*;

    logic partial;
    assign partial = (|col_hit) && !(&col_hit);

    // R9: lane sync loss forces the search state.
    assert_sync_loss_unalign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_sync_i) |=> (state_q == ST_UNALIGN));

    // R6: unaligned output carries the fault column.
    assert_fault_when_unaligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !col_aligned_o |-> (rx_ctrl_o == NUM_LANES'(1) && rx_data_o[7:0] == FAULT_SEQ));

    // R2: a lock starts the confirmation phase.
    assert_lock_to_det1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && (&lane_sync_i)) |=> (state_q == ST_DET1));

    // R4: full alignment is entered only from the last confirm or first fail level.
    assert_align_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALIGN && $past(state_q) != ST_ALIGN) |->
        ($past(state_q) == ST_DET3 || $past(state_q) == ST_FAIL1));

    // R5: a partial column while confirming restarts the search.
    assert_det_partial_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((&lane_sync_i) && !skip && partial &&
         (state_q == ST_DET1 || state_q == ST_DET2 || state_q == ST_DET3))
        |=> (state_q == ST_UNALIGN));

    // R7: a partial column at the last fail level drops alignment.
    assert_fail3_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&lane_sync_i) && partial && state_q == ST_FAIL3) |=> (state_q == ST_UNALIGN));

    // R7: a partial column in full alignment enters the first fail level.
    assert_align_to_fail1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&lane_sync_i) && partial && state_q == ST_ALIGN) |=> (state_q == ST_FAIL1));

    // R10: the status output follows the state with one register of delay.
    assert_status_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNALIGN) |=> !col_aligned_o);

endmodule

bind col_deskew_ctrl col_deskew_ctrl_chk #(.NUM_LANES(NUM_LANES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .lane_sync_i   (lane_sync_i),
    .state_q       (state_q),
    .lock          (lock),
    .skip          (skip),
    .col_hit       (col_hit),
    .rx_data_o     (rx_data_o),
    .rx_ctrl_o     (rx_ctrl_o),
    .col_aligned_o (col_aligned_o)
);

// File: tb/col_deskew_ctrl_tb_top.sv
// Bench: sweeps lane skews and walks the alignment hysteresis.
module col_deskew_ctrl_tb_top;

    localparam int BLEN = 128;
    localparam logic [31:0] FAULT_DATA = 32'h0100_009C;
    localparam logic [3:0]  FAULT_CTRL = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lane_sync_i = 4'hF;
    logic [31:0] lane_data_i = '0;
    logic [3:0]  lane_ctrl_i = '0;
    logic [31:0] rx_data_o;
    logic [3:0]  rx_ctrl_o;
    logic        col_aligned_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] bb [4][BLEN];
    logic       bc [4][BLEN];
    int         dly [4];
    logic       al [BLEN];
    bit          seen_first;
    logic [31:0] first_data;
    logic [3:0]  first_ctrl;
    int          fault_bad;

    always #5 clk = ~clk;

    col_deskew_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane_sync_i   (lane_sync_i),
        .lane_data_i   (lane_data_i),
        .lane_ctrl_i   (lane_ctrl_i),
        .rx_data_o     (rx_data_o),
        .rx_ctrl_o     (rx_ctrl_o),
        .col_aligned_o (col_aligned_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Plain data columns carry their index; every 16th column from 4 is /A/.
    task automatic build_base();
        for (int i = 0; i < BLEN; i++) begin
            for (int l = 0; l < 4; l++) begin
                if (i % 16 == 4) begin
                    bb[l][i] = 8'h7C; bc[l][i] = 1'b1;
                end else begin
                    bb[l][i] = 8'(i); bc[l][i] = 1'b0;
                end
            end
        end
    endtask

    task automatic set_col(input int idx, input int kind); // 0 plain, 1 full, 2 partial
        for (int l = 0; l < 4; l++) begin
            if (kind == 1 || (kind == 2 && l == 0)) begin
                bb[l][idx] = 8'h7C; bc[l][idx] = 1'b1;
            end else begin
                bb[l][idx] = 8'(idx); bc[l][idx] = 1'b0;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lane_sync_i = 4'hF; lane_data_i = '0; lane_ctrl_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rx_data_o == FAULT_DATA && rx_ctrl_o == FAULT_CTRL && !col_aligned_o,
              "R1 reset column", {rx_data_o[27:0], rx_ctrl_o}, {FAULT_DATA[27:0], FAULT_CTRL});
        rst_n = 1'b1;
    endtask

    // Streams len columns; sample before driving. drop_at < 0 keeps sync high.
    task automatic run(input int len, input int drop_at);
        seen_first = 1'b0; fault_bad = 0;
        for (int i = 0; i < BLEN; i++) al[i] = 1'b0;
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            if (t >= 2) al[t-2] = col_aligned_o;
            if (col_aligned_o && !seen_first) begin
                seen_first = 1'b1; first_data = rx_data_o; first_ctrl = rx_ctrl_o;
            end
            if (!col_aligned_o && (rx_data_o != FAULT_DATA || rx_ctrl_o != FAULT_CTRL))
                fault_bad++;
            lane_sync_i = (t == drop_at) ? 4'b1011 : 4'hF;
            for (int l = 0; l < 4; l++) begin
                int k = t - dly[l];
                lane_data_i[8*l +: 8] = (k >= 0) ? bb[l][k] : 8'h00;
                lane_ctrl_i[l]        = (k >= 0) ? bc[l][k] : 1'b0;
            end
        end
    endtask

    initial begin : watchdog_p
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main_p
        // R2 R4 R6: skew sweep, lane 0 fixed, lanes 1 and 3 over 0..7.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                build_base();
                dly[0] = 0; dly[1] = a; dly[3] = b; dly[2] = (a + b) % 8;
                do_reset();
                run(72, -1);
                check(seen_first && first_data == 32'h3535_3535 && first_ctrl == 4'h0,
                      "R2 R4 first aligned column", first_data, 32'h3535_3535);
                check(fault_bad == 0, "R6 fault while unaligned", 32'(fault_bad), 0);
            end
        end

        // R3: 8-clock skew never locks.
        build_base();
        dly[0] = 0; dly[1] = 0; dly[2] = 0; dly[3] = 8;
        do_reset();
        run(110, -1);
        check(!seen_first, "R3 skew beyond window", 32'(seen_first), 0);
        check(fault_bad == 0, "R3 R6 fault column held", 32'(fault_bad), 0);

        // R4 R5: partial column while confirming restarts the search.
        build_base();
        dly[0] = 0; dly[1] = 0; dly[2] = 0; dly[3] = 0;
        set_col(28, 2);
        do_reset();
        run(100, -1);
        check(al[53] == 1'b0, "R5 no alignment at 53", 32'(al[53]), 0);
        check(seen_first && first_data == 32'h5555_5555, "R5 realigned column",
              first_data, 32'h5555_5555);

        // R7 R10: three partial columns keep status, the fourth drops it.
        build_base();
        set_col(56, 2); set_col(58, 2); set_col(60, 2); set_col(62, 2);
        do_reset();
        run(70, -1);
        check(al[52] == 1'b0 && al[53] == 1'b1, "R4 R10 status rises at 53",
              {30'd0, al[52], al[53]}, 32'h1);
        check(al[62] == 1'b1, "R7 status kept at third fail level", 32'(al[62]), 1);
        check(al[63] == 1'b0, "R7 status dropped after fourth", 32'(al[63]), 0);
        check(fault_bad == 0, "R6 fault after drop", 32'(fault_bad), 0);

        // R8: complete columns step back, plain columns hold.
        build_base();
        set_col(56, 2); set_col(58, 2); set_col(59, 1); set_col(61, 1);
        set_col(63, 2); set_col(65, 2); set_col(68, 0); set_col(70, 2); set_col(76, 2);
        do_reset();
        run(82, -1);
        check(al[75] == 1'b1, "R8 step back and hold", 32'(al[75]), 1);
        check(al[76] == 1'b1, "R7 R8 status at last fail level", 32'(al[76]), 1);
        check(al[77] == 1'b0, "R7 drop after walk", 32'(al[77]), 0);

        // R9: one-cycle sync loss on lane 2.
        build_base();
        do_reset();
        run(74, 70);
        check(al[69] == 1'b1, "R9 aligned before sync loss", 32'(al[69]), 1);
        check(al[70] == 1'b0, "R9 status after sync loss", 32'(al[70]), 0);
        check(fault_bad == 0, "R9 R6 fault after sync loss", 32'(fault_bad), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule